// File: doc/BRIEF.md
# Banked Aperture Address Mapper

This block translates host accesses that land in a 64 KB legacy memory window into addresses in a larger video memory. The window is split into two 32 KB halves, and each half has its own page register. The byte address sent to memory is the selected page number times the bank unit, plus the offset within the window. It then wraps to the installed memory size. The translation is purely combinational, so the mapped address is ready in the same cycle as the host request.

Software programs the mapper through an index/data register pair. All extended registers sit at indices 10h and above, and they stay locked until the unlock key is written to the environment register.

The other controls are:
- A control bit that chooses whether upper-half offsets are counted from the start of that half or from the start of the window.
- A mode bit that selects 4 KB or 16 KB bank units.
- A linear bypass that skips banking entirely.

Top module: `aperture_mapper`

## Requirements
- R1: After reset the index register reads 00h, the environment register reads 00h (locked), both page registers are 0 and the control, mode and size registers are 0. With that state, a host offset maps to the same address.
- R2: A write with `reg_sel`=0 loads the index register. Reading with `reg_sel`=0 returns the index, and reading with `reg_sel`=1 returns the register the index selects. Indices that are not implemented read 00h.
- R3: The environment register sits at index 0Fh and is always reachable. It reads back the full byte written. The extended registers are unlocked exactly while its low nibble equals 5.
- R4: While locked, writes to indices 10h and above are dropped and reads of them return 00h. The translation keeps using the values already held.
- R5: In banked mode, a host offset below 8000h maps to page0 × unit + offset. The page0 register is at index 45h. Host address bits above bit 15 are ignored.
- R6: When bit 0 of the control register (index 40h) is 1, an offset at or above 8000h maps to page1 × unit + (offset − 8000h). The page1 register is at index 46h.
- R7: When control bit 0 is 0, an offset at or above 8000h maps to page1 × unit + offset. Offset here is the full 16-bit window offset.
- R8: The unit is 4096 bytes when bit 4 of the mode register (index 4Ah) is 0, and 16384 bytes when it is 1.
- R9: When bit 2 of the mode register is 1, the mapped address is the full host address wrapped to the memory size, and the page registers are not used.
- R10: The size register sits at index 54h. The result is taken modulo the memory size: code 2 means 512 KB, 4 means 1 MB, and 8 means 2 MB. Any other code, including 0, means 1 MB.
- R11: The mapped address follows the host address combinationally in the same cycle. A register write takes effect for accesses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the index register, 1 the data register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| host_addr | input | ADDR_W | Host address; bits 15:0 are the window offset in banked mode |
| mem_addr | output | ADDR_W | Mapped video-memory address |

## Verification
The bench targets the upper-half fold. A design that ignored the control bit would place every upper-half access 32 KB too high or too low. The bench also probes the split at offset 8000h, where choosing the wrong page register moves the access into another bank, and large pages in 16 KB units, where a shift that is too short points the access into the wrong bank.

Unusual size codes and addresses near the top of memory show whether wrapping uses the right modulus. Writes sent while the block is locked, and writes sent after it is locked again, must leave both the read-back values and the mapping untouched. A leaky lock would instead show the new page values.

// File: rtl/apm_pkg.sv
package apm_pkg;
    localparam int DATA_W = 8;

    localparam logic [7:0] IDX_ENV       = 8'h0F;
    localparam logic [7:0] IDX_LOCK_BASE = 8'h10;
    localparam logic [7:0] IDX_CTRL      = 8'h40;
    localparam logic [7:0] IDX_PAGE0     = 8'h45;
    localparam logic [7:0] IDX_PAGE1     = 8'h46;
    localparam logic [7:0] IDX_MODE      = 8'h4A;
    localparam logic [7:0] IDX_SIZE      = 8'h54;
    localparam logic [3:0] UNLOCK_KEY    = 4'h5;

    localparam int MODE_LINEAR_BIT = 2;
    localparam int MODE_BIG_BIT    = 4;
    localparam int SHIFT_SMALL     = 12;
    localparam int SHIFT_BIG       = 14;

    typedef struct packed {
        logic [DATA_W-1:0] index;
        logic [DATA_W-1:0] env;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] page0;
        logic [DATA_W-1:0] page1;
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] size;
    } apm_regs_t;

    // log2 of the installed memory size in bytes
    function automatic logic [4:0] size_log2(input logic [DATA_W-1:0] code);
        case (code)
            8'h02:   return 5'd19;
            8'h04:   return 5'd20;
            8'h08:   return 5'd21;
            default: return 5'd20;
        endcase
    endfunction
endpackage

// File: rtl/apm_regfile.sv
module apm_regfile
    import apm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output apm_regs_t         regs,
    output logic              unlocked
);
    apm_regs_t regs_d, regs_q;
    logic      open_q;
    logic      reachable;
    logic [DATA_W-1:0] data_rd;

    assign open_q    = (regs_q.env[3:0] == UNLOCK_KEY);
    assign reachable = (regs_q.index < IDX_LOCK_BASE) || open_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            if (!reg_sel) begin
                regs_d.index = reg_wdata;
            end else if (regs_q.index == IDX_ENV) begin
                regs_d.env = reg_wdata;
            end else if (reachable) begin
                case (regs_q.index)
                    IDX_CTRL:  regs_d.ctrl  = reg_wdata;
                    IDX_PAGE0: regs_d.page0 = reg_wdata;
                    IDX_PAGE1: regs_d.page1 = reg_wdata;
                    IDX_MODE:  regs_d.mode  = reg_wdata;
                    IDX_SIZE:  regs_d.size  = reg_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        data_rd = '0;
        if (regs_q.index == IDX_ENV) begin
            data_rd = regs_q.env;
        end else if (reachable) begin
            case (regs_q.index)
                IDX_CTRL:  data_rd = regs_q.ctrl;
                IDX_PAGE0: data_rd = regs_q.page0;
                IDX_PAGE1: data_rd = regs_q.page1;
                IDX_MODE:  data_rd = regs_q.mode;
                IDX_SIZE:  data_rd = regs_q.size;
                default:   data_rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign reg_rdata = reg_sel ? data_rd : regs_q.index;
    assign regs      = regs_q;
    assign unlocked  = open_q;
endmodule

// File: rtl/apm_size_mask.sv
module apm_size_mask
    import apm_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic [DATA_W-1:0] size_code,
    output logic [ADDR_W-1:0] mask
);
    logic [4:0] lg;
    assign lg = size_log2(size_code);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign mask[i] = (5'(i) < lg);
    end
endmodule

// File: rtl/apm_translate.sv
module apm_translate
    import apm_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  apm_regs_t         regs,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int CALC_W = DATA_W + SHIFT_BIG + 1;

    logic              upper;
    logic              fold;
    logic [DATA_W-1:0] page;
    logic [CALC_W-1:0] base, offs, sum;
    logic [ADDR_W-1:0] raw;

    always_comb begin
        upper = host_addr[15];
        fold  = upper && regs.ctrl[0];
        page  = upper ? regs.page1 : regs.page0;
        base  = regs.mode[MODE_BIG_BIT] ? (CALC_W'(page) << SHIFT_BIG)
                                        : (CALC_W'(page) << SHIFT_SMALL);
        offs  = fold ? CALC_W'(host_addr[14:0]) : CALC_W'(host_addr[15:0]);
        sum   = base + offs;
        raw   = regs.mode[MODE_LINEAR_BIT] ? host_addr : ADDR_W'(sum);
        mem_addr = raw & mask;
    end
endmodule

// File: rtl/aperture_mapper.sv
module aperture_mapper
    import apm_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [ADDR_W-1:0] mem_addr
);
    apm_regs_t         regs;
    logic              unlocked;
    logic [ADDR_W-1:0] mask;

    apm_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .regs      (regs),
        .unlocked  (unlocked)
    );

    apm_size_mask #(.ADDR_W(ADDR_W)) u_mask (
        .size_code (regs.size),
        .mask      (mask)
    );

    apm_translate #(.ADDR_W(ADDR_W)) u_xlat (
        .regs      (regs),
        .host_addr (host_addr),
        .mask      (mask),
        .mem_addr  (mem_addr)
    );
endmodule

// File: rtl/apm_checker.sv
module apm_checker
    import apm_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              unlocked,
    input apm_regs_t         regs,
    input logic [ADDR_W-1:0] mem_addr
);
    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_sel |=> regs.index == $past(reg_wdata)); // R2

    AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel && regs.index == IDX_ENV && reg_wdata[3:0] == UNLOCK_KEY
        |=> unlocked); // R3

    AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked && reg_sel && regs.index >= IDX_LOCK_BASE |-> reg_rdata == 8'h00); // R4

    AST_LOCKED_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(regs.page0) && $stable(regs.page1)); // R4

    AST_ADDR_IN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr >> size_log2(regs.size)) == '0); // R10
endmodule

bind aperture_mapper apm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .unlocked  (unlocked),
    .regs      (regs),
    .mem_addr  (mem_addr)
);

// File: tb/aperture_mapper_test.sv
module aperture_mapper_test;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] host_addr = '0;
    logic [AW-1:0] mem_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    aperture_mapper #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_addr(host_addr), .mem_addr(mem_addr)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
        wr(1'b0, idx);
        wr(1'b1, d);
    endtask

    task automatic rreg(input logic [7:0] idx, output logic [7:0] v);
        wr(1'b0, idx);
        reg_sel = 1'b1;
        #1 v = reg_rdata;
    endtask

    function automatic logic [AW-1:0] model(input logic [AW-1:0] ha, input int p0, input int p1,
                                            input bit c0, input bit big, input bit lin,
                                            input int code);
        longint sz, unit, off, raw;
        int pg;
        sz = (code == 2) ? 64'd524288 : (code == 8) ? 64'd2097152 : 64'd1048576;
        if (lin) begin
            raw = longint'(ha);
        end else begin
            unit = big ? 64'd16384 : 64'd4096;
            off  = longint'(ha[15:0]);
            pg   = ha[15] ? p1 : p0;
            if (ha[15] && c0) off = off - 32768;
            raw = longint'(pg) * unit + off;
        end
        return AW'(raw % sz);
    endfunction

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int codes[5] = '{2, 4, 8, 0, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_sel = 1'b0; #1 check("R1 index", 32'(reg_rdata), 32'h00);
        rreg(8'h0F, rv); check("R1 env", 32'(rv), 32'h00);
        host_addr = 21'h01234; #1 check("R1 map", 32'(mem_addr), 32'h01234);

        // R2 index readback
        wr(1'b0, 8'h5C); reg_sel = 1'b0; #1 check("R2 index", 32'(reg_rdata), 32'h5C);

        // R4 locked write dropped, read zero
        wreg(8'h45, 8'h33);
        rreg(8'h45, rv); check("R4 locked read", 32'(rv), 32'h00);
        host_addr = 21'h00010; #1 check("R4 locked map", 32'(mem_addr), 32'h00010);

        // R3 unlock
        wreg(8'h0F, 8'hA5);
        rreg(8'h0F, rv); check("R3 env byte", 32'(rv), 32'hA5);
        rreg(8'h45, rv); check("R3 R4 dropped write", 32'(rv), 32'h00);
        wreg(8'h45, 8'h33);
        rreg(8'h45, rv); check("R3 page0 writable", 32'(rv), 32'h33);
        rreg(8'h47, rv); check("R2 unimplemented", 32'(rv), 32'h00);

        // R5..R8, R10 sweeps
        for (int c = 0; c < 20; c++) begin
            bit c0 = c[0];
            bit big = c[1];
            int code = codes[c >> 2];
            int p0 = (8'h11 + c * 13) & 8'hFF;
            int p1 = c[2] ? ((p0 + 8) & 8'hFF) : ((8'hC7 - c) & 8'hFF);
            wreg(8'h40, {7'd0, c0});
            wreg(8'h4A, big ? 8'h10 : 8'h00);
            wreg(8'h54, 8'(code));
            wreg(8'h45, 8'(p0));
            wreg(8'h46, 8'(p1));
            for (int k = 0; k < 256; k++) begin
                logic [15:0] off = 16'(k * 16'h0101 + c);
                string tag;
                host_addr = {5'h1A, off};
                if (big) tag = "R8 R10";
                else if (!off[15]) tag = "R5 R10";
                else tag = c0 ? "R6 R10" : "R7 R10";
                #1 check(tag, 32'(mem_addr), 32'(model(host_addr, p0, p1, c0, big, 1'b0, code)));
            end
            host_addr = 21'h07FFF; #1
            check("R5 split low", 32'(mem_addr), 32'(model(host_addr, p0, p1, c0, big, 1'b0, code)));
            host_addr = 21'h08000; #1
            check("R6 R7 split high", 32'(mem_addr), 32'(model(host_addr, p0, p1, c0, big, 1'b0, code)));
        end

        // R10 top of memory wrap with max pages
        for (int s = 0; s < 5; s++) begin
            wreg(8'h54, 8'(codes[s]));
            wreg(8'h4A, 8'h10);
            wreg(8'h45, 8'hFF);
            host_addr = 21'h07ABC; #1
            check("R10 wrap", 32'(mem_addr), 32'(model(host_addr, 255, 0, 1'b0, 1'b1, 1'b0, codes[s])));
        end

        // R9 linear bypass
        wreg(8'h40, 8'h01);
        wreg(8'h46, 8'h77);
        for (int s = 0; s < 5; s++) begin
            wreg(8'h54, 8'(codes[s]));
            wreg(8'h4A, 8'h14);
            for (int k = 0; k < 64; k++) begin
                host_addr = AW'(k * 32'h0000_8E3B + s);
                #1 check("R9 linear", 32'(mem_addr),
                         32'(model(host_addr, 255, 119, 1'b1, 1'b1, 1'b1, codes[s])));
            end
        end

        // R11 same-cycle response and next-access update
        wreg(8'h4A, 8'h00);
        wreg(8'h54, 8'h08);
        wreg(8'h45, 8'h02);
        host_addr = 21'h00100; #1 check("R11 comb a", 32'(mem_addr), 32'h02100);
        host_addr = 21'h00200; #1 check("R11 comb b", 32'(mem_addr), 32'h02200);
        wreg(8'h45, 8'h09);
        #1 check("R11 page update", 32'(mem_addr), 32'h09200);

        // R4 relock: writes dropped and mapping unchanged
        wreg(8'h0F, 8'h00);
        wreg(8'h45, 8'h40);
        #1 check("R4 relock map", 32'(mem_addr), 32'h09200);
        rreg(8'h45, rv); check("R4 relock read", 32'(rv), 32'h00);
        wreg(8'h0F, 8'h05);
        rreg(8'h45, rv); check("R4 R3 value kept", 32'(rv), 32'h09);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule